// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures a signal with a 20-bit binary counter. It works in one of two modes, and the source selection picks the mode. In frequency mode it counts rising edges of one of two intermediate-frequency inputs during a gate window. The window is a whole number of 1 ms timebase ticks. In period mode it waits for a rising edge on a slow logic-level pilot input. From that edge to the next rising edge of the pilot, it counts pulses of a selectable reference rate.

A controller pulses the start input for one cycle. The source and gate codes are captured on that cycle, the counter and the overflow flag are cleared, and busy goes high. When the measurement ends, busy drops and the result holds until the next start. A result is trustworthy only when busy and overflow both read 0. If the count would pass its top value, overflow is set and the count saturates. All three measured inputs pass through a two-flop synchroniser before edge detection.

Top module: `gp_meas_counter`

## Requirements
- R1: After reset, `count_o` (20 bits wide) is 0, `busy_o` is 0 and `over_o` is 0.
- R2: A one-cycle `start_i` clears the count and overflow flag and raises `busy_o` from the next cycle. It captures `gate_sel_i` and `src_sel_i`. A start during a running measurement abandons that measurement and begins a new one.
- R3: With `src_sel_i` = 0 the block counts rising edges of `if1_i`, and with `src_sel_i` = 1 it counts rising edges of `if2_i`, while the gate is open. Edges on the unselected inputs are not counted.
- R4: In frequency mode `busy_o` stays high for exactly 4^g × MS_CYCLES clock cycles, where g is `gate_sel_i` read as a binary number with bit 0 as its LSB. The codes 0, 1, 2 and 3 give 1 ms, 4 ms, 16 ms and 64 ms.
- R5: With `src_sel_i` = 2 or 3 (period mode), the gate opens on the first rising edge of `pilot_i` after start and closes on the next rising edge. `busy_o` stays high until the gate closes.
- R6: In period mode, `gate_sel_i` = 0, 1 and 2 count reference pulses of one per REF0_DIV, REF1_DIV and REF2_DIV clocks (50 kHz, 150 kHz, 900 kHz). Code 3 counts every clock, so the result equals the pilot period in clock cycles. For a divided rate the result lies between floor and ceiling of period/divider.
- R7: An increment at the top count value sets `over_o` and leaves `count_o` at all ones. Both hold until the next start.
- R8: While idle and without a start, `count_o`, `over_o` and `busy_o` do not change, whatever the measured inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the crystal-rate reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command: clear and begin a measurement |
| gate_sel_i | input | 2 | Gate time code (frequency) or reference rate code (period) |
| src_sel_i | input | 2 | 0: IF input 1, 1: IF input 2, 2/3: pilot input in period mode |
| if1_i | input | 1 | First intermediate-frequency input (logic level) |
| if2_i | input | 1 | Second intermediate-frequency input (logic level) |
| pilot_i | input | 1 | Low-frequency pilot input for period measurement |
| count_o | output | CNT_W (20) | Measured count |
| busy_o | output | 1 | Measurement in progress |
| over_o | output | 1 | Count overflowed; result invalid |

## Verification
Frequency runs drive random pulse trains of varied high and low lengths on the selected IF input. At the same time the other IF input and the pilot toggle at random, so a count that equals the driven rise count shows that the source mux rejects the wrong inputs. Every gate code is run, and the busy duration is measured cycle by cycle, which separates the four window lengths. Period runs use random pilot periods and start offsets under all four reference codes. The crystal code gives an exact cycle count and the divided codes give a bounded count. A narrow second instance is driven past its top value to expose saturation, the sticky flag and the clearing on restart.

// File: rtl/gp_meas_pkg.sv
`timescale 1ns/1ps
package gp_meas_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_OPEN} meas_state_e;

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned IDX_IF1 = 0;
  localparam int unsigned IDX_IF2 = 1;
  localparam int unsigned IDX_PILOT = 2;

  // gate length in ms ticks: 1, 4, 16, 64
  function automatic logic [6:0] gate_ms(input logic [1:0] sel);
    return 7'(1) << {sel, 1'b0};
  endfunction
endpackage

// File: rtl/gp_meas_edge_sync.sv
`timescale 1ns/1ps
module gp_meas_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], async_i};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/gp_meas_gate_timer.sv
`timescale 1ns/1ps
module gp_meas_gate_timer
  import gp_meas_pkg::*;
#(
  parameter int unsigned MS_CYCLES = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic [1:0] gate_sel_i,
  output logic       gate_end_o
);
  localparam int unsigned MS_W = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;

  logic [MS_W-1:0] ms_cnt_q;
  logic [6:0]      ms_done_q;
  logic [6:0]      ms_need;
  logic            ms_tick;

  assign ms_need    = gate_ms(gate_sel_i);
  assign ms_tick    = run_i && (ms_cnt_q == MS_W'(MS_CYCLES - 1));
  assign gate_end_o = ms_tick && (ms_done_q == ms_need - 7'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_cnt_q  <= '0;
      ms_done_q <= '0;
    end else if (clear_i) begin
      ms_cnt_q  <= '0;
      ms_done_q <= '0;
    end else if (run_i) begin
      ms_cnt_q <= ms_tick ? '0 : ms_cnt_q + 1'b1;
      if (ms_tick) ms_done_q <= ms_done_q + 7'd1;
    end
  end
endmodule

// File: rtl/gp_meas_ref_gen.sv
`timescale 1ns/1ps
module gp_meas_ref_gen #(
  parameter int unsigned DIV0 = 4000,
  parameter int unsigned DIV1 = 1333,
  parameter int unsigned DIV2 = 222
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o
);
  logic [2:0] tap;

  for (genvar k = 0; k < 3; k++) begin : g_div
    localparam int unsigned DIV = (k == 0) ? DIV0 : (k == 1) ? DIV1 : DIV2;
    localparam int unsigned W   = (DIV > 1) ? $clog2(DIV) : 1;
    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap = (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else              cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    assign tap[k] = wrap;
  end

  always_comb begin
    case (sel_i)
      2'd0:    pulse_o = tap[0];
      2'd1:    pulse_o = tap[1];
      2'd2:    pulse_o = tap[2];
      default: pulse_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/gp_meas_counter.sv
`timescale 1ns/1ps
module gp_meas_counter
  import gp_meas_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned MS_CYCLES = 200000,
  parameter int unsigned REF0_DIV  = 4000,
  parameter int unsigned REF1_DIV  = 1333,
  parameter int unsigned REF2_DIV  = 222,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic [1:0]       src_sel_i,
  input  logic             if1_i,
  input  logic             if2_i,
  input  logic             pilot_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             over_o
);
  meas_state_e      state_q, state_d;
  logic [1:0]       gsel_q, src_q;
  logic [CNT_W-1:0] count_q;
  logic             over_q;

  logic [NUM_IN-1:0] in_vec, rise;
  logic              period_mode, sel_rise, gate_end, ref_pulse, inc;

  assign in_vec = {pilot_i, if2_i, if1_i};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    gp_meas_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(in_vec[i]),
      .rise_o (rise[i])
    );
  end

  assign period_mode = src_q[1];
  assign sel_rise    = period_mode ? rise[IDX_PILOT]
                     : (src_q[0] ? rise[IDX_IF2] : rise[IDX_IF1]);

  gp_meas_gate_timer #(.MS_CYCLES(MS_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .run_i     ((state_q == ST_OPEN) && !period_mode),
    .gate_sel_i(gsel_q),
    .gate_end_o(gate_end)
  );

  gp_meas_ref_gen #(.DIV0(REF0_DIV), .DIV1(REF1_DIV), .DIV2(REF2_DIV)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .sel_i  (gsel_q),
    .pulse_o(ref_pulse)
  );

  assign inc = (state_q == ST_OPEN) && (period_mode ? ref_pulse : sel_rise);

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = src_sel_i[1] ? ST_ARM : ST_OPEN;
    end else begin
      case (state_q)
        ST_ARM:  if (sel_rise) state_d = ST_OPEN;
        ST_OPEN: if (period_mode ? sel_rise : gate_end) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gsel_q  <= '0;
      src_q   <= '0;
      count_q <= '0;
      over_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        gsel_q  <= gate_sel_i;
        src_q   <= src_sel_i;
        count_q <= '0;
        over_q  <= 1'b0;
      end else if (inc) begin
        if (&count_q) over_q  <= 1'b1;   // saturate, flag
        else          count_q <= count_q + 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign over_o  = over_q;
endmodule

// File: rtl/gp_meas_counter_chk.sv
`timescale 1ns/1ps
module gp_meas_counter_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_o,
  input logic             busy_o,
  input logic             over_o
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && (count_o == '0) && !over_o));

  a_r3_count_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (count_o >= $past(count_o)));

  a_r7_over_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !start_i) |=> over_o);

  a_r7_over_saturated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> (&count_o));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(count_o) && $stable(over_o)));
endmodule

bind gp_meas_counter gp_meas_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .count_o(count_o),
  .busy_o (busy_o),
  .over_o (over_o)
);

// File: tb/gp_meas_counter_tb_top.sv
`timescale 1ns/1ps
module gp_meas_counter_tb_top;
  localparam int MS = 16, D0 = 36, D1 = 12, D2 = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, if1, if2, pilot, busy, over;
  logic [1:0] gsel, src;
  logic [19:0] count;

  logic start_b, pilot_b, busy_b, over_b;
  logic [5:0] count_b;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  gp_meas_counter #(.MS_CYCLES(MS), .REF0_DIV(D0), .REF1_DIV(D1), .REF2_DIV(D2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gate_sel_i(gsel), .src_sel_i(src),
    .if1_i(if1), .if2_i(if2), .pilot_i(pilot),
    .count_o(count), .busy_o(busy), .over_o(over));

  gp_meas_counter #(.CNT_W(6), .MS_CYCLES(MS), .REF0_DIV(D0), .REF1_DIV(D1), .REF2_DIV(D2)) ovf_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .gate_sel_i(2'd3), .src_sel_i(2'd2),
    .if1_i(1'b0), .if2_i(1'b0), .pilot_i(pilot_b),
    .count_o(count_b), .busy_o(busy_b), .over_o(over_b));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] g, input logic [1:0] s);
    if1 = 1'b0; if2 = 1'b0; pilot = 1'b0;
    repeat (4) @(negedge clk);
    gsel = g; src = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; gsel = 2'($urandom_range(0, 3)); src = 2'($urandom_range(0, 3));
  endtask

  task automatic run_freq(input logic [1:0] g, input logic [1:0] s);
    int t_len, n_busy, rises;
    logic lv, nv;
    logic [19:0] held;
    t_len = (1 << (2 * int'(g))) * MS;
    do_start(g, s);
    n_busy = 0; rises = 0; lv = 1'b0;
    for (int i = 1; i <= t_len + 3; i++) begin
      if (busy) n_busy++;
      nv = (i >= 2 && i <= t_len - 4) ? 1'($urandom_range(0, 1)) : 1'b0;
      if (nv && !lv) rises++;
      lv = nv;
      if (s[0]) begin if2 = nv; if1 = 1'($urandom_range(0, 1)); end
      else      begin if1 = nv; if2 = 1'($urandom_range(0, 1)); end
      pilot = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    check("R4 gate length", n_busy, t_len);
    check("R3 rise count of selected input", count, rises);
    check("R7 no overflow", over, 0);
    held = count;
    for (int i = 0; i < 12; i++) begin
      if1 = i[0]; if2 = ~i[0]; pilot = i[1];
      @(negedge clk);
    end
    check("R8 idle count held", count, held);
    check("R8 idle busy low", busy, 0);
  endtask

  task automatic run_period(input logic [1:0] g, input int a, input int per);
    int last, d, lo, hi;
    do_start(g, 2'd2 | 2'($urandom_range(0, 1)));
    last = a + per + per / 2 + 4;
    for (int i = 1; i <= last; i++) begin
      if (i == a + per)     check("R5 busy before closing edge", busy, 1);
      if (i == a + per + 3) check("R5 busy after closing edge", busy, 0);
      pilot = ((i >= a && i < a + per / 2) || (i >= a + per && i < a + per + per / 2));
      if1 = 1'($urandom_range(0, 1)); if2 = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    pilot = 1'b0;
    if (g == 2'd3) begin
      check("R6 crystal-rate period count", count, per);
    end else begin
      d  = (g == 2'd0) ? D0 : (g == 2'd1) ? D1 : D2;
      lo = per / d; hi = (per + d - 1) / d;
      checks++;
      if (int'(count) < lo || int'(count) > hi) begin
        failures++;
        $display("FAIL R6 divided period count actual=%0d expected=%0d..%0d", count, lo, hi);
      end
    end
    check("R7 period no overflow", over, 0);
  endtask

  task automatic ovf_run(input int per);
    pilot_b = 1'b0;
    repeat (4) @(negedge clk);
    start_b = 1'b1; @(negedge clk); start_b = 1'b0;
    for (int i = 1; i <= per + per / 2 + 6; i++) begin
      pilot_b = ((i >= 3 && i < 3 + per / 2) || (i >= 3 + per && i < 3 + per + per / 2));
      @(negedge clk);
    end
    pilot_b = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; gsel = '0; src = '0;
    if1 = 1'b0; if2 = 1'b0; pilot = 1'b0; start_b = 1'b0; pilot_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset count", count, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset over", over, 0);
    check("R1 count width", $bits(count), 20);

    for (int k = 0; k < 6; k++) run_freq(2'($urandom_range(0, 2)), 2'($urandom_range(0, 1)));
    run_freq(2'd3, 2'd0);
    run_freq(2'd1, 2'd1);

    for (int g = 0; g < 4; g++) run_period(2'(g), $urandom_range(2, 6), $urandom_range(40, 120));
    run_period(2'd3, 2, 20);

    // R2: restart while busy
    do_start(2'd3, 2'd0);
    for (int i = 0; i < 20; i++) begin if1 = i[1]; @(negedge clk); end
    check("R2 busy before restart", busy, 1);
    do_start(2'd0, 2'd1);
    check("R2 restart clears count", count, 0);
    begin
      int n = 0;
      while (busy && n < 5000) begin n++; @(negedge clk); end
      check("R4 gate length after restart", n, MS);
    end

    // R7: saturation on the narrow instance
    ovf_run(100);
    check("R7 saturated count", count_b, 63);
    check("R7 overflow flag", over_b, 1);
    check("R7 busy ends", busy_b, 0);
    repeat (10) @(negedge clk);
    check("R7 overflow held", over_b, 1);
    ovf_run(30);
    check("R2 start clears overflow", over_b, 0);
    check("R2 count after restart", count_b, 30);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule